// File: doc/BRIEF.md
# Gated Bit-Slice Arithmetic/Logic Unit

This block is an N-bit arithmetic/logic unit assembled from identical one-bit slices joined by a carry ripple from bit 0 upward. Three control bits and a carry input choose the operation. One bit inverts operand A on its way into every slice. One bit lets operand B through or forces it to zero. The mode bit either lets the carry chain run or blocks it at each slice. The function set comes from this gating, not from a selector over separately computed results. With the carry blocked, each slice reduces to an exclusive-OR of its two gated operand bits, which gives the bitwise functions. With the carry running, each slice is a full adder, which gives the arithmetic functions.

The gated operands and the ripple chain are combinational. The result word and the carry out are captured in one output register. A set of inputs presented before a rising clock edge therefore appears at the outputs after that edge. The block is meant to sit in a datapath that needs pass, complement, exclusive-OR, sum, increment, negate and reverse-subtract operations from one small adder structure.

Top module: `gated_slice_alu`

## Requirements
- R1: While `rst_n` is low, `f_out` and `carry_out` are 0 after every rising clock edge, whatever the other inputs are.
- R2: With `arith_en`=0, the result is chosen by {`pass_b`,`inv_a`}: 00 gives A, 01 gives bitwise not A, 10 gives A xor B, 11 gives A xnor B.
- R3: With `arith_en`=0, `carry_in` has no effect on `f_out`.
- R4: With `arith_en`=0, `carry_out` is 0.
- R5: With `arith_en`=1 and `carry_in`=0, {`pass_b`,`inv_a`} = 00, 01, 10, 11 gives A, not A, A plus B, and (not A) plus B, modulo 2^WIDTH. `carry_out` is the carry from the top bit of that sum.
- R6: With `arith_en`=1 and `carry_in`=1, the same codes give A plus 1, (not A) plus 1, A plus B plus 1, and (not A) plus B plus 1 (that is, B minus A). `carry_out` is the carry from the top bit.
- R7: Results are registered with a latency of one cycle. Inputs sampled at a rising edge appear on the outputs from that edge until the next one, and a new operation can be issued every cycle.
- R8: A carry ripples through every slice. All-ones A plus 1 gives a zero result with `carry_out`=1, and B minus A with B less than A gives the two's-complement negative value with `carry_out`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| arith_en | input | 1 | 1 lets the carry ripple (arithmetic), 0 blocks it (bitwise) |
| inv_a | input | 1 | 1 inverts operand A at every slice |
| pass_b | input | 1 | 1 passes operand B, 0 forces it to zero |
| carry_in | input | 1 | Carry into bit 0 |
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B |
| f_out | output | WIDTH | Registered result |
| carry_out | output | 1 | Registered carry from the top slice, 0 in bitwise mode |

## Verification
The bench builds the block with WIDTH=4. At that width the whole input space, 16 values of A times 16 values of B times the 16 combinations of mode, both selects and carry, is 4096 operations. Every one is issued back to back against a behavioural model. This covers every carry pattern through the chain, including a ripple across all four slices, and every case where carry_in must be ignored. Directed operations at the wrap-around and reverse-subtract corners are added on top of the sweep.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Per-operation gating controls shared by every slice
    typedef struct packed {
        logic arith;   // carry chain enabled
        logic inv_a;   // complement operand A
        logic pass_b;  // let operand B through
    } slice_ctrl_t;

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  slice_ctrl_t ctrl_i,
    input  logic        a_bit_i,
    input  logic        b_bit_i,
    input  logic        carry_i,
    output logic        f_bit_o,
    output logic        carry_o
);

    logic x_op;     // A after optional inversion
    logic y_op;     // B after gating
    logic c_gated;  // incoming carry after mode gating

    always_comb begin
        x_op    = a_bit_i ^ ctrl_i.inv_a;
        y_op    = b_bit_i & ctrl_i.pass_b;
        c_gated = carry_i & ctrl_i.arith;
        f_bit_o = y_op ^ (x_op ^ c_gated);
        carry_o = (c_gated & x_op) | (y_op & (x_op ^ c_gated));
    end

endmodule

// File: rtl/alu_ripple_chain.sv
module alu_ripple_chain
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  slice_ctrl_t      ctrl_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] f_o,
    output logic             carry_o
);

    localparam int CHAIN_LEN = WIDTH + 1;

    logic [CHAIN_LEN-1:0] link;

    assign link[0] = carry_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_slice u_slice (
            .ctrl_i  (ctrl_i),
            .a_bit_i (a_i[i]),
            .b_bit_i (b_i[i]),
            .carry_i (link[i]),
            .f_bit_o (f_o[i]),
            .carry_o (link[i+1])
        );
    end

    // A top slice with a blocked carry can still produce a carry term; mask it
    assign carry_o = link[CHAIN_LEN-1] & ctrl_i.arith;

endmodule

// File: rtl/gated_slice_alu.sv
module gated_slice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arith_en,
    input  logic             inv_a,
    input  logic             pass_b,
    input  logic             carry_in,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] f_out,
    output logic             carry_out
);

    localparam int SUM_W = WIDTH + 1;

    typedef struct packed {
        logic [WIDTH-1:0] f;
        logic             c;
    } result_t;

    slice_ctrl_t      ctrl;
    logic [WIDTH-1:0] chain_f;
    logic             chain_c;
    result_t          state_d;
    result_t          state_q;

    assign ctrl = '{arith: arith_en, inv_a: inv_a, pass_b: pass_b};

    alu_ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .ctrl_i  (ctrl),
        .a_i     (a_in),
        .b_i     (b_in),
        .carry_i (carry_in),
        .f_o     (chain_f),
        .carry_o (chain_c)
    );

    always_comb begin
        state_d   = state_q;
        state_d.f = chain_f;
        state_d.c = chain_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign f_out     = state_q.f;
    assign carry_out = state_q.c;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (f_out == '0 && !carry_out)); // R1

    AST_PASS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!arith_en && !inv_a && !pass_b) |=> (f_out == $past(a_in))); // R2

    AST_XNOR: assert property (@(posedge clk) disable iff (!rst_n)
        (!arith_en && inv_a && pass_b) |=> (f_out == ~($past(a_in) ^ $past(b_in)))); // R2

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        !arith_en |=> !carry_out); // R4

    AST_FULL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (arith_en && !inv_a && pass_b) |=>
        ({carry_out, f_out} == (SUM_W'($past(a_in)) + SUM_W'($past(b_in))
                                + SUM_W'($past(carry_in))))); // R5

    AST_REVERSE_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (arith_en && inv_a && pass_b && carry_in) |=>
        (f_out == WIDTH'($past(b_in) - $past(a_in)))); // R6

endmodule

// File: tb/gated_slice_alu_tb_top.sv
module gated_slice_alu_tb_top;

    localparam int W = 4;
    localparam int WATCHDOG_CYCLES = 200000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         arith_en, inv_a, pass_b, carry_in;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] f_out;
    logic         carry_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        logic [W-1:0] f;
        logic         c;
        string        tag;
        int           due;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;  // 50 MHz

    always @(posedge clk) cyc = cyc + 1;

    gated_slice_alu #(.WIDTH(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .arith_en  (arith_en),
        .inv_a     (inv_a),
        .pass_b    (pass_b),
        .carry_in  (carry_in),
        .a_in      (a_in),
        .b_in      (b_in),
        .f_out     (f_out),
        .carry_out (carry_out)
    );

    // Behavioural model taken from the requirement text
    function automatic logic [W:0] model(input logic m, input logic s1, input logic s0,
                                         input logic c, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
        logic [W-1:0] opa;
        logic [W-1:0] opb;
        logic [W:0]   sum;
        opa = s0 ? ~a : a;
        opb = s1 ? b : '0;
        if (!m) begin
            return {1'b0, opa ^ opb};   // R2 R3 R4
        end
        sum = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, c};  // R5 R6
        return sum;
    endfunction

    // Driver: apply one operation at a falling edge and queue its expected result
    task automatic drive(input logic m, input logic s1, input logic s0, input logic c,
                         input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        logic [W:0] e;
        exp_t item;
        @(negedge clk);
        arith_en = m; pass_b = s1; inv_a = s0; carry_in = c; a_in = a; b_in = b;
        e = model(m, s1, s0, c, a, b);
        item.f = e[W-1:0];
        item.c = e[W];
        item.tag = tag;
        item.due = cyc + 1;   // R7: one register between inputs and outputs
        sb.push_back(item);
    endtask

    // Monitor: compare once the capturing edge has passed
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (f_out !== e.f || carry_out !== e.c) begin
                errors++;
                $display("FAIL %s f/c actual=%h/%b expected=%h/%b", e.tag, f_out, carry_out, e.f, e.c);
            end
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        arith_en = 1'b1; pass_b = 1'b1; inv_a = 1'b0; carry_in = 1'b1;
        a_in = '1; b_in = '1;
        repeat (3) @(negedge clk);
        // R1: outputs stay clear under reset despite live inputs
        checks++;
        if (f_out !== '0 || carry_out !== 1'b0) begin
            errors++;
            $display("FAIL R1 f/c actual=%h/%b expected=0/0", f_out, carry_out);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive sweep, back to back (R7)
        for (int ctl = 0; ctl < 16; ctl++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    logic m, s1, s0, c;
                    string tag;
                    m = ctl[3]; s1 = ctl[2]; s0 = ctl[1]; c = ctl[0];
                    if (!m) tag = c ? "R3 R4 R7" : "R2 R4 R7";
                    else    tag = c ? "R6 R7" : "R5 R7";
                    drive(m, s1, s0, c, W'(a), W'(b), tag);
                end
            end
        end

        // R8: ripple corners
        drive(1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 4'h0, "R8 all-ones plus one");
        drive(1'b1, 1'b1, 1'b1, 1'b1, 4'h5, 4'h3, "R8 B minus A negative");
        drive(1'b1, 1'b1, 1'b0, 1'b1, 4'h8, 4'h7, "R8 full ripple");
        drive(1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 4'h9, "R8 negate zero");
        // R3: same bitwise op with carry toggled back to back
        drive(1'b0, 1'b1, 1'b0, 1'b0, 4'hA, 4'h6, "R3 carry low");
        drive(1'b0, 1'b1, 1'b0, 1'b1, 4'hA, 4'h6, "R3 carry high");

        repeat (4) @(negedge clk);
        done = 1;
        if (sb.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL R7 pending actual=%0d expected=0", sb.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule